// File: doc/BRIEF.md
# Serial Autobaud Lock and Acknowledge Unit

This unit sits on an idle-high asynchronous receive line and learns the host's bit rate from one known character. It waits for the byte 0x7F, framed as one start bit, eight data bits sent least significant bit first, an even parity bit and one stop bit. For 0x7F the even parity bit is 1. The line therefore falls for the start bit, stays high for data bits 0 to 6, drops for data bit 7 and rises again for parity and stop.

A free-running counter measures the time from the start-bit falling edge to the rising edge after data bit 7. That span is nine bit times. The unit divides it by nine, rounding to nearest, to get the number of system clocks per bit. Measurements with the wrong shape are thrown away and the unit goes back to waiting for a falling edge. Once a measurement is accepted, the unit locks for the rest of the reset period. It then transmits the acknowledge byte 0x79 at the learned rate and starts receiving further bytes, all framed with 8 data bits, even parity and 1 stop bit. Received bytes leave on a valid/ready stream with a per-byte parity-error flag. A one-entry holding register provides back-pressure. While `rx_valid_o` is high, the data and flag stay stable until a cycle with `rx_ready_i` high takes them. A byte whose stop-bit sample falls while the register is still full is discarded.

Top module: `abr_link`

## Requirements
- R1: After reset, `locked_o` is 0, `div_o` is 0, `tx_o` is 1 and `rx_valid_o` is 0.
- R2: After a well-formed sync character, `locked_o` goes to 1 and `div_o` equals round(T/9). T is the clock count from the start-bit fall to the rise that follows data bit 7.
- R3: On locking, the unit sends exactly one frame on `tx_o`, at `div_o` clocks per bit: a low start bit, 0x79 least significant bit first, even parity bit 1, then a high stop bit. `tx_o` stays 1 while unlocked.
- R4: A candidate is rejected, and the unit stays unlocked and keeps waiting, in either of two cases: the low interval ending the measurement lies outside div ± div/2 clocks, or the resulting divisor is below MIN_DIV. A later valid sync still locks.
- R5: A candidate is rejected if the line goes low before 1.5 bit times have passed since the rise that ended the measurement, since parity and stop must both be high.
- R6: After locking, each frame whose stop-bit sample is high is delivered as `rx_data_o`, with `rx_perr_o`=0 when the data bits plus the parity bit hold an even count of ones.
- R7: A frame whose parity bit makes the count of ones odd is delivered with `rx_perr_o`=1.
- R8: Locking happens once per reset. A later 0x7F on the line is delivered as an ordinary data byte, `div_o` keeps its value, and no second acknowledge is sent.
- R9: While `rx_valid_o`=1 and `rx_ready_i`=0, `rx_valid_o`, `rx_data_o` and `rx_perr_o` hold. A frame completing while the register is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| tx_o | output | 1 | Serial transmit line, idle high |
| div_o | output | CNT_W | Learned clocks per bit; 0 until locked |
| locked_o | output | 1 | High once a sync character has been accepted |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the byte in a cycle where valid is high |
| rx_data_o | output | 8 | Received data byte |
| rx_perr_o | output | 1 | Parity error flag for `rx_data_o` |

## Verification
The embedded properties check on every cycle the following:
- `locked_o` never falls and `div_o` never changes once set.
- Any locked divisor is at least MIN_DIV.
- `tx_o` stays high before locking.
- A byte is only offered after locking.
- A stalled stream holds its data and flag.

Only the bench scenarios can show the rest: the numeric value of the rounded divisor at two bit rates, the bit pattern of the acknowledge frame, rejection of misshapen sync candidates followed by recovery, the parity flag on real frames, and the discarding of a byte that arrives while the holding register is full.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam logic [7:0] ACK_CODE = 8'h79;
  localparam int BITS_IN_SPAN = 9;
  localparam int FRAME_LEN = 11;

  typedef enum logic [2:0] {
    M_IDLE, M_START, M_HIGH, M_LOW, M_STOP, M_LOCK
  } meas_st_e;

  typedef enum logic [1:0] {
    R_IDLE, R_START, R_BITS
  } rx_st_e;
endpackage

// File: rtl/abr_sync.sv
module abr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/abr_measure.sv
module abr_measure import abr_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  output logic             locked_o,
  output logic             lock_pulse_o,
  output logic [CNT_W-1:0] div_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NUM_W = CNT_W + 4;

  meas_st_e st;
  logic rx_q;
  logic [CNT_W-1:0] cnt, t_fall, div_r, div_c, low2, win_lo, win_hi, stop_len;
  logic [NUM_W-1:0] num;
  logic fit_ok;

  // rounded divide of the nine-bit span
  assign num    = {4'd0, cnt} + NUM_W'(BITS_IN_SPAN / 2);
  assign div_c  = CNT_W'(num / NUM_W'(BITS_IN_SPAN));
  assign low2   = cnt - t_fall;
  assign win_lo = div_c - (div_c >> 1);
  assign win_hi = div_c + (div_c >> 1);
  assign fit_ok = (div_c >= CNT_W'(MIN_DIV)) && (low2 >= win_lo) && (low2 <= win_hi);
  assign stop_len = div_r + (div_r >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; rx_q <= 1'b1; cnt <= '0; t_fall <= '0;
      div_r <= '0; lock_pulse_o <= 1'b0;
    end else begin
      rx_q <= rx_s;
      lock_pulse_o <= 1'b0;
      if ((st == M_START || st == M_HIGH || st == M_LOW) && cnt == CNT_MAX) begin
        st <= M_IDLE;
      end else begin
        case (st)
          M_IDLE:  if (rx_q && !rx_s) begin cnt <= CNT_W'(1); st <= M_START; end
          M_START: begin cnt <= cnt + 1'b1; if (rx_s) st <= M_HIGH; end
          M_HIGH:  begin
            cnt <= cnt + 1'b1;
            if (!rx_s) begin t_fall <= cnt; st <= M_LOW; end
          end
          M_LOW: begin
            cnt <= cnt + 1'b1;
            if (rx_s) begin
              if (fit_ok) begin div_r <= div_c; cnt <= '0; st <= M_STOP; end
              else st <= M_IDLE;
            end
          end
          M_STOP: begin
            cnt <= cnt + 1'b1;
            if (!rx_s) st <= M_IDLE;
            else if (cnt >= stop_len) begin st <= M_LOCK; lock_pulse_o <= 1'b1; end
          end
          default: ;
        endcase
      end
    end
  end

  assign locked_o = (st == M_LOCK);
  assign div_o    = locked_o ? div_r : '0;

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o && $stable(div_o));
  // R4
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> div_o >= CNT_W'(MIN_DIV));
endmodule

// File: rtl/abr_rx.sv
module abr_rx import abr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rx_s,
  input  logic [CNT_W-1:0] div_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             perr_o
);
  rx_st_e st;
  logic rx_q;
  logic [CNT_W-1:0] cnt;
  logic [3:0] idx;
  logic [9:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; rx_q <= 1'b1; cnt <= '0; idx <= '0; shreg <= '0;
      valid_o <= 1'b0; data_o <= '0; perr_o <= 1'b0;
    end else begin
      rx_q <= rx_s;
      if (valid_o && ready_i) valid_o <= 1'b0;
      case (st)
        R_IDLE: if (en_i && rx_q && !rx_s) begin cnt <= '0; st <= R_START; end
        R_START: begin
          if (cnt >= (div_i >> 1)) begin
            cnt <= '0; idx <= '0;
            st <= rx_s ? R_IDLE : R_BITS;
          end else cnt <= cnt + 1'b1;
        end
        R_BITS: begin
          if (cnt >= div_i - 1'b1) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[9:1]};
            idx   <= idx + 1'b1;
            if (idx == 4'd9) begin
              st <= R_IDLE;
              if (rx_s && !valid_o) begin
                valid_o <= 1'b1;
                data_o  <= shreg[8:1];
                perr_o  <= ^shreg[9:1];
              end
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(perr_o));
  // R6
  offer_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> en_i);
endmodule

// File: rtl/abr_tx.sv
module abr_tx import abr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tx_o
);
  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [3:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; cnt <= '0; left <= '0;
    end else if (go_i) begin
      sh <= {1'b1, ^ACK_CODE, ACK_CODE, 1'b0};
      left <= 4'(FRAME_LEN); cnt <= '0;
    end else if (left != 0) begin
      if (cnt >= div_i - 1'b1) begin
        cnt <= '0; sh <= {1'b1, sh[FRAME_LEN-1:1]}; left <= left - 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end
  assign tx_o = sh[0];
endmodule

// File: rtl/abr_link.sv
module abr_link #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [CNT_W-1:0] div_o,
  output logic             locked_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_perr_o
);
  logic rx_s, lock_pulse;

  abr_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s));

  abr_measure #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_meas (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .locked_o(locked_o),
    .lock_pulse_o(lock_pulse), .div_o(div_o));

  abr_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .go_i(lock_pulse), .div_i(div_o), .tx_o(tx_o));

  abr_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(locked_o), .rx_s(rx_s), .div_i(div_o),
    .ready_i(rx_ready_i), .valid_o(rx_valid_o), .data_o(rx_data_o), .perr_o(rx_perr_o));

  // R3
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> tx_o);
endmodule

// File: tb/abr_link_tb_top.sv
module abr_link_tb_top;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rst_n = 1'b0, rx_i = 1'b1, rx_ready_i = 1'b1;
  logic tx_o, locked_o, rx_valid_o, rx_perr_o;
  logic [CNT_W-1:0] div_o;
  logic [7:0] rx_data_o;
  int total = 0, bad = 0, txlow = 0;
  logic [8:0] exp_q[$];
  logic [8:0] got;

  always #2 clk = ~clk;

  abr_link #(.CNT_W(CNT_W), .MIN_DIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tx_o(tx_o), .div_o(div_o),
    .locked_o(locked_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_data_o(rx_data_o), .rx_perr_o(rx_perr_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic drive(input logic lvl, input int n);
    rx_i = lvl;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par, input int n);
    logic [10:0] f;
    f = {1'b1, par, d, 1'b0};
    for (int i = 0; i < 11; i++) drive(f[i], n);
    drive(1'b1, 2 * n);
  endtask

  // driver: pushes the expected item then drives the line
  task automatic send_byte(input logic [7:0] d, input bit perr, input int n, input bit push);
    if (push) exp_q.push_back({perr, d});
    send_frame(d, (^d) ^ perr, n);
  endtask

  task automatic check_ack(input int n);
    logic [10:0] want;
    int waited;
    want = {1'b1, 1'b1, 8'h79, 1'b0};
    waited = 0;
    while (tx_o === 1'b1 && waited < 4000) begin @(negedge clk); waited++; end
    chk(tx_o === 1'b0, "R3 ack start seen", tx_o, 0);
    repeat (n / 2) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      chk(tx_o === want[i], "R3 ack bit", tx_o, want[i]);
      repeat (n) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_i = 1'b1; rx_ready_i = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!tx_o) txlow++;
    if (rst_n && rx_valid_o && rx_ready_i) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected byte actual=%0h expected=none", {rx_perr_o, rx_data_o});
      end else begin
        got = exp_q.pop_front();
        if ({rx_perr_o, rx_data_o} !== got) begin
          bad++;
          $display("FAIL R6/R7 byte actual=%0h expected=%0h", {rx_perr_o, rx_data_o}, got);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int snap;
    do_reset();
    // R1
    @(negedge clk);
    chk(locked_o === 1'b0, "R1 locked", locked_o, 0);
    chk(div_o === '0, "R1 div", div_o, 0);
    chk(tx_o === 1'b1, "R1 tx", tx_o, 1);
    chk(rx_valid_o === 1'b0, "R1 valid", rx_valid_o, 0);

    // R4: closing low interval three bits long
    drive(0, 40); drive(1, 280); drive(0, 120); drive(1, 300);
    chk(locked_o === 1'b0, "R4 stays unlocked", locked_o, 0);
    chk(txlow == 0, "R4 no ack", txlow, 0);

    // R2/R3 valid sync at 40 clocks per bit after the rejection
    fork
      send_frame(8'h7F, 1'b1, 40);
      check_ack(40);
    join
    chk(locked_o === 1'b1, "R2 locked", locked_o, 1);
    chk(div_o == 40, "R2 divisor 40", div_o, 40);
    drive(1, 100);

    // R6 / R7
    send_byte(8'hA5, 0, 40, 1);
    send_byte(8'h00, 0, 40, 1);
    send_byte(8'hFF, 0, 40, 1);
    send_byte(8'h3C, 1, 40, 1);
    send_byte(8'h81, 1, 40, 1);
    drive(1, 40);
    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);

    // R8 second sync is data
    snap = txlow;
    send_byte(8'h7F, 0, 40, 1);
    drive(1, 40);
    chk(div_o == 40, "R8 divisor kept", div_o, 40);
    chk(txlow == snap, "R8 no second ack", txlow, snap);
    chk(exp_q.size() == 0, "R8 sync byte delivered", exp_q.size(), 0);

    // R9 back-pressure
    rx_ready_i = 1'b0;
    send_byte(8'h5A, 0, 40, 1);
    send_byte(8'hC3, 0, 40, 0);
    @(negedge clk);
    chk(rx_valid_o === 1'b1, "R9 valid held", rx_valid_o, 1);
    chk(rx_data_o === 8'h5A, "R9 data held", rx_data_o, 8'h5A);
    @(posedge clk); #1 rx_ready_i = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R9 first byte taken", exp_q.size(), 0);
    chk(rx_valid_o === 1'b0, "R9 second byte dropped", rx_valid_o, 0);

    // R5: line drops one bit after the measuring rise
    do_reset();
    drive(0, 40); drive(1, 280); drive(0, 40); drive(1, 40); drive(0, 40); drive(1, 300);
    chk(locked_o === 1'b0, "R5 stays unlocked", locked_o, 0);

    // R2/R3 at 23 clocks per bit
    fork
      send_frame(8'h7F, 1'b1, 23);
      check_ack(23);
    join
    chk(div_o == 23, "R2 divisor 23", div_o, 23);
    drive(1, 60);
    send_byte(8'h96, 0, 23, 1);
    send_byte(8'h96, 1, 23, 1);
    drive(1, 30);
    chk(exp_q.size() == 0, "R7 bytes at 23 delivered", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule